// File: doc/BRIEF.md
# Borrow-Steered Maximum Register

This block registers the larger of two unsigned operands, `opa` and `opb`. It does not use a magnitude comparator followed by a multiplexer tree. Instead, a ripple carry chain evaluates `opa + ~opb + 1`. The sum bits of that chain are never formed, and only the final carry is kept. The inverse of that carry is the borrow, which is high exactly when `opa` is less than `opb`.

The borrow acts as one synchronous-load control shared by every bit of the result register. When the borrow is high, the register takes `opb` through its load-data port. Otherwise it takes `opa` through its ordinary data path.

A second registered bit reports which operand was taken. Both registers update only on clock edges where `in_valid` is high. A synchronous active-high reset clears both registers.

Top module: `cmp_select_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes all zeros and `took_b` becomes 0 on that edge.
- R2: On a rising edge with `in_valid` high, `result` becomes the unsigned maximum of `opa` and `opb`, visible one register stage later.
- R3: On a rising edge with `in_valid` high, `took_b` becomes 1 exactly when `opa < opb` (unsigned), and 0 otherwise.
- R4: When `opa` equals `opb` on a valid edge, `result` takes `opa` and `took_b` reads 0.
- R5: On a rising edge with `in_valid` low, `result` and `took_b` keep their previous values whatever `opa` and `opb` hold.
- R6: The operand extremes give the correct maximum and flag: all zeros against all ones in either order, and both operands all ones.
- R7: The choice is correct for every operand pair at a small width and for arbitrary pairs at a wide width, including pairs that differ only in the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; registers update only when high |
| opa | input | WIDTH | First unsigned operand (the X side) |
| opb | input | WIDTH | Second unsigned operand (the Y side, load data) |
| result | output | WIDTH | Registered maximum of the sampled operands |
| took_b | output | 1 | Registered flag, 1 when `opb` was selected |

## Verification
On every valid edge, the assertions compare the registered result and flag against a plain unsigned comparison of the previous operands. They also check the equal-operand rule, and that both registers hold still on idle edges. The reset value, the exhaustive sweep of every pair at four bits, and the extreme and random cases at 32 bits are shown only by the bench's scenarios. In those scenarios the expected maximum is computed arithmetically and compared at the ports.

// File: rtl/cmp_select_pkg.sv
package cmp_select_pkg;

    // Which operand the result register captured.
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    // Majority function: carry out of one full-adder cell.
    function automatic logic fa_carry(input logic a, input logic b, input logic cin);
        return (a & b) | (a & cin) | (b & cin);
    endfunction

    // Map a borrow bit onto the selection encoding.
    function automatic pick_e pick_from_borrow(input logic borrow);
        return borrow ? PICK_B : PICK_A;
    endfunction

endpackage

// File: rtl/borrow_chain.sv
// Ripple carry chain for a + ~b + 1. Only the final carry is produced;
// its inverse is the unsigned borrow (a < b).
module borrow_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             borrow
);
    import cmp_select_pkg::*;

    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] carry;

    assign carry[0] = 1'b1;   // the +1 of the two's complement

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign carry[i+1] = fa_carry(a[i], ~b[i], carry[i]);
    end

    assign borrow = ~carry[CHAIN-1];

endmodule

// File: rtl/syncload_reg.sv
// Register bank with an enable and a bank-wide synchronous load that
// replaces the normal data with the load data.
module syncload_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sload,
    input  logic [WIDTH-1:0] sdata,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] CLEAR = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CLEAR;
        end else if (en) begin
            if (sload) q <= sdata;
            else       q <= d;
        end
    end

endmodule

// File: rtl/cmp_select_reg.sv
module cmp_select_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             took_b
);
    import cmp_select_pkg::*;

    logic  borrow;
    pick_e pick_q;

    borrow_chain #(.WIDTH(WIDTH)) u_chain (
        .a      (opa),
        .b      (opb),
        .borrow (borrow)
    );

    syncload_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .sload (borrow),
        .sdata (opb),
        .d     (opa),
        .q     (result)
    );

    always_ff @(posedge clk) begin
        if (rst)           pick_q <= PICK_A;
        else if (in_valid) pick_q <= pick_from_borrow(borrow);
    end

    assign took_b = (pick_q == PICK_B);

    // R2: registered value is the unsigned maximum of the sampled operands
    assert_max_value_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> result == (($past(opa) < $past(opb)) ? $past(opb) : $past(opa)));

    // R3: flag reports opa < opb
    assert_flag_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> took_b == ($past(opa) < $past(opb)));

    // R4: equal operands take opa with the flag low
    assert_equal_takes_a_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opa == opb) |=> (!took_b && result == $past(opa)));

    // R5: idle edges leave both registers untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(took_b)));

endmodule

// File: tb/cmp_select_reg_bench.sv
module cmp_select_reg_bench;

    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic          n_valid = 1'b0;
    logic [NW-1:0] n_a = '0, n_b = '0;
    logic [NW-1:0] n_res;
    logic          n_flag;

    logic          w_valid = 1'b0;
    logic [WW-1:0] w_a = '0, w_b = '0;
    logic [WW-1:0] w_res;
    logic          w_flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cmp_select_reg #(.WIDTH(NW)) u_cmp_select_reg (
        .clk(clk), .rst(rst), .in_valid(n_valid),
        .opa(n_a), .opb(n_b), .result(n_res), .took_b(n_flag));

    cmp_select_reg #(.WIDTH(WW)) u_cmp_select_reg_wide (
        .clk(clk), .rst(rst), .in_valid(w_valid),
        .opa(w_a), .opb(w_b), .result(w_res), .took_b(w_flag));

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic narrow_op(input logic [NW-1:0] a, input logic [NW-1:0] b, input string req);
        logic [NW-1:0] exp;
        exp = (a < b) ? b : a;
        @(negedge clk);
        n_a = a; n_b = b; n_valid = 1'b1;
        @(posedge clk); #1;
        n_valid = 1'b0;
        check(req, WW'(n_res), WW'(exp));
        check(req, WW'(n_flag), WW'(a < b));
    endtask

    task automatic wide_op(input logic [WW-1:0] a, input logic [WW-1:0] b, input string req);
        logic [WW-1:0] exp;
        exp = (a < b) ? b : a;
        @(negedge clk);
        w_a = a; w_b = b; w_valid = 1'b1;
        @(posedge clk); #1;
        w_valid = 1'b0;
        check(req, w_res, exp);
        check(req, WW'(w_flag), WW'(a < b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [WW-1:0] ra, rb, held;
        logic          held_f;

        // R1: reset state
        repeat (2) @(posedge clk); #1;
        check("R1 narrow result", WW'(n_res), '0);
        check("R1 narrow flag", WW'(n_flag), '0);
        check("R1 wide result", w_res, '0);
        @(negedge clk); rst = 1'b0;

        // R7 / R2 / R3 / R4: exhaustive at four bits
        for (int i = 0; i < (1 << NW); i++) begin
            for (int j = 0; j < (1 << NW); j++) begin
                narrow_op(NW'(i), NW'(j), (i == j) ? "R4 equal narrow" : "R7 sweep R2 R3");
            end
        end

        // R6: extremes at the wide width
        wide_op('0, '1, "R6 zero vs ones");
        wide_op('1, '0, "R6 ones vs zero");
        wide_op('1, '1, "R6 both ones R4");
        wide_op('0, '0, "R6 both zero R4");

        // R7: pairs that differ only in bit 0
        wide_op(32'h8000_0000, 32'h8000_0001, "R7 lsb diff");
        wide_op(32'h7FFF_FFFF, 32'h7FFF_FFFE, "R7 lsb diff");
        wide_op(32'h8000_0000, 32'h7FFF_FFFF, "R7 msb unsigned R3");

        // R7 / R2: random wide pairs
        for (int k = 0; k < 500; k++) begin
            ra = $urandom;
            rb = (k % 5 == 0) ? ra : $urandom;
            wide_op(ra, rb, "R7 random R2");
        end

        // R5: idle edges hold state
        wide_op(32'h0000_0010, 32'h0000_0020, "R5 setup");
        held = w_res; held_f = w_flag;
        @(negedge clk);
        w_a = '1; w_b = 32'h0000_0001; w_valid = 1'b0;
        repeat (3) @(posedge clk); #1;
        check("R5 hold result", w_res, held);
        check("R5 hold flag", WW'(w_flag), WW'(held_f));
        narrow_op(4'h2, 4'h9, "R5 setup narrow");
        @(negedge clk);
        n_a = 4'hF; n_b = 4'h0;
        @(posedge clk); #1;
        check("R5 hold narrow", WW'(n_res), WW'(4'h9));
        check("R5 hold narrow flag", WW'(n_flag), WW'(1'b1));

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid reset result", w_res, '0);
        check("R1 mid reset flag", WW'(n_flag), '0);
        @(negedge clk); rst = 1'b0;

        finish_run();
    end

endmodule